// File: doc/BRIEF.md
# Custom-opcode bit-manipulation execute unit

This block is the execute stage for a group of 64-bit bit-manipulation operations that sit in the first custom major-opcode slot of a RISC-V style core. It receives the raw 32-bit instruction word together with the two source operand values. It decodes the word and computes one of these operations:

- an add with the second operand shifted left,
- a rotate right by an immediate, in full-width and low-word forms,
- a leading-zero count or a first-zero search,
- a byte reversal of the full register, or of the low word with sign extension,
- a per-byte zero test,
- a single-bit test.

Result, write enable and illegal flag are registered, so they appear one clock after the instruction is presented. The core drives a new instruction every cycle. It writes the result back when the write enable is set, and raises an exception when the illegal flag is set. Register reads, hazards, privilege and bitfield extraction belong to other blocks.

Top module: `bmx_exec`

## Requirements
- R1: While reset (active-low `rst_n`) is low, `result_o` is 0 and `wr_en_o` and `illegal_o` are both 0. Reset is asynchronous.
- R2: Outputs change only at a rising clock edge. They reflect the instruction and operands sampled at that edge, so a new input is not visible before the next edge.
- R3: Opcode bits [6:0]=0001011, funct3 [14:12]=001 and funct7 [31:25] in 0000000..0000011 give rs1 + (rs2 << funct7[1:0]), modulo 2^64. A shift of 0 is a plain add.
- R4: Bits [31:26]=000100 (with opcode 0001011 and funct3 001) rotate rs1 right by the 6-bit amount in bits [25:20].
- R5: Funct7 0001010 rotates rs1[31:0] right by bits [24:20]. The 32-bit result is sign-extended to 64 bits.
- R6: The rs2 field [24:20] must be 00000. Under that rule, funct7 1000011 returns the count of leading zeros of rs1, and funct7 1000010 returns the count of leading ones of rs1. Each count is 64 when no qualifying bit exists.
- R7: With rs2 field 00000, funct7 1000001 returns rs1 with its eight bytes in reverse order.
- R8: With rs2 field 00000, funct7 1001000 returns the byte-reversed low 32 bits of rs1, sign-extended to 64 bits.
- R9: With rs2 field 00000, funct7 1000000 returns 0xFF in each byte whose rs1 byte is zero, and 0x00 in every other byte.
- R10: Bits [31:26]=100010 return rs1 bit number [25:20], zero-extended to 64 bits.
- R11: Some words carry opcode 0001011 but match none of the patterns above. Examples are funct3 other than 001, an unlisted funct7, and a unary form with a nonzero rs2 field. Such a word gives `illegal_o`=1, `wr_en_o`=0 and `result_o`=0.
- R12: A legal word gives `wr_en_o`=1 only when rd [11:7] is nonzero. The result is still computed when rd is 0.
- R13: A word whose opcode is not 0001011 gives `illegal_o`=0, `wr_en_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 32 | Raw instruction word |
| rs1_i | input | 64 | First source operand value |
| rs2_i | input | 64 | Second source operand value |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Registered register-write enable |
| illegal_o | output | 1 | Registered illegal-instruction flag |

## Verification
The embedded properties check several relations on every clock:

- a foreign opcode never writes or flags,
- an rd of zero never writes,
- a custom-0 word with the wrong funct3 always flags and returns zero,
- the leading counts never exceed 64,
- the bit test leaves the upper 63 bits clear,
- both word-form results are proper sign extensions.

Only the bench's scenarios show the actual arithmetic values. These are the shifted sums with wrap-around, the rotation amounts 0 and 32, the all-zero and all-one counts, the byte orderings and the per-byte zero mask. The one-cycle latency is also shown only by the scenarios.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

    localparam int XLEN     = 64;
    localparam int HALF     = XLEN / 2;
    localparam int NBYTES   = XLEN / 8;
    localparam int AMT_W    = $clog2(XLEN);
    localparam int CNT_W    = $clog2(XLEN) + 1;
    localparam int INSN_W   = 32;

    localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;
    localparam logic [2:0] F3_BITOPS   = 3'b001;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ADDSL,
        OP_ROR,
        OP_RORW,
        OP_CLZ,
        OP_FF0,
        OP_REV,
        OP_REVW,
        OP_ZBYTE,
        OP_BTEST,
        OP_BAD
    } bmx_op_e;

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            wr_en;
        logic            illegal;
    } bmx_out_t;

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
    import bmx_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output bmx_op_e           op,
    output logic [AMT_W-1:0]  amt,
    output logic              is_custom
);

    logic [6:0] f7;
    logic [4:0] rs2f;
    logic       unary_ok;

    always_comb begin
        f7        = insn[31:25];
        rs2f      = insn[24:20];
        unary_ok  = (rs2f == 5'd0);
        is_custom = (insn[6:0] == OPC_CUSTOM0);
        amt       = insn[25:20];
        op        = OP_NONE;
        if (is_custom) begin
            op = OP_BAD;
            if (insn[14:12] == F3_BITOPS) begin
                if (f7[6:2] == 5'b00000) begin
                    op  = OP_ADDSL;
                    amt = {{(AMT_W-2){1'b0}}, f7[1:0]};
                end else if (insn[31:26] == 6'b000100) begin
                    op = OP_ROR;
                end else if (f7 == 7'b0001010) begin
                    op  = OP_RORW;
                    amt = {1'b0, insn[24:20]};
                end else if (insn[31:26] == 6'b100010) begin
                    op = OP_BTEST;
                end else if (unary_ok) begin
                    unique case (f7)
                        7'b1000011: op = OP_CLZ;
                        7'b1000010: op = OP_FF0;
                        7'b1000001: op = OP_REV;
                        7'b1001000: op = OP_REVW;
                        7'b1000000: op = OP_ZBYTE;
                        default:    op = OP_BAD;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/bmx_lead_count.sv
module bmx_lead_count #(
    parameter int W  = 64,
    parameter int CW = $clog2(W) + 1
) (
    input  logic [W-1:0]  vec,
    input  logic          invert,
    output logic [CW-1:0] cnt
);

    logic [W-1:0] v;

    always_comb begin
        v   = invert ? ~vec : vec;
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (v[i]) cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/bmx_byte_ops.sv
module bmx_byte_ops #(
    parameter int W = 64,
    localparam int NB = W / 8
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] rev,
    output logic [W-1:0] zmask
);

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign rev[8*b +: 8]   = x[8*(NB-1-b) +: 8];
        assign zmask[8*b +: 8] = (x[8*b +: 8] == 8'h00) ? 8'hFF : 8'h00;
    end

endmodule

// File: rtl/bmx_exec.sv
module bmx_exec
    import bmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [XLEN-1:0]   rs1_i,
    input  logic [XLEN-1:0]   rs2_i,
    output logic [XLEN-1:0]   result_o,
    output logic              wr_en_o,
    output logic              illegal_o
);

    bmx_op_e          op;
    logic [AMT_W-1:0] amt;
    logic             is_custom;
    logic [CNT_W-1:0] lead_cnt;
    logic [XLEN-1:0]  rev_w;
    logic [XLEN-1:0]  zmask_w;
    logic [2*XLEN-1:0] rot_full;
    logic [XLEN-1:0]   rot_word;
    bmx_out_t         out_d, out_q;

    bmx_decode u_dec (
        .insn      (insn_i),
        .op        (op),
        .amt       (amt),
        .is_custom (is_custom)
    );

    bmx_lead_count #(.W(XLEN), .CW(CNT_W)) u_cnt (
        .vec    (rs1_i),
        .invert (op == OP_FF0),
        .cnt    (lead_cnt)
    );

    bmx_byte_ops #(.W(XLEN)) u_bytes (
        .x     (rs1_i),
        .rev   (rev_w),
        .zmask (zmask_w)
    );

    always_comb begin
        rot_full = {rs1_i, rs1_i} >> amt;
        rot_word = {rs1_i[HALF-1:0], rs1_i[HALF-1:0]} >> amt[AMT_W-2:0];
        out_d          = '0;
        out_d.illegal  = (op == OP_BAD);
        out_d.wr_en    = is_custom && (op != OP_BAD) && (insn_i[11:7] != 5'd0);
        unique case (op)
            OP_ADDSL: out_d.result = rs1_i + (rs2_i << amt[1:0]);
            OP_ROR:   out_d.result = rot_full[XLEN-1:0];
            OP_RORW:  out_d.result = {{HALF{rot_word[HALF-1]}}, rot_word[HALF-1:0]};
            OP_CLZ,
            OP_FF0:   out_d.result = {{(XLEN-CNT_W){1'b0}}, lead_cnt};
            OP_REV:   out_d.result = rev_w;
            OP_REVW:  out_d.result = {{HALF{rev_w[XLEN-1]}}, rev_w[XLEN-1:HALF]};
            OP_ZBYTE: out_d.result = zmask_w;
            OP_BTEST: out_d.result = {{(XLEN-1){1'b0}}, rs1_i[amt]};
            default:  out_d.result = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o  = out_q.result;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (result_o == '0 && !wr_en_o && !illegal_o));

    p_foreign_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] != OPC_CUSTOM0) |=> (!illegal_o && !wr_en_o));

    p_rd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[11:7] == 5'd0) |=> !wr_en_o);

    p_bad_funct3_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] == OPC_CUSTOM0 && insn_i[14:12] != F3_BITOPS)
        |=> (illegal_o && !wr_en_o && result_o == '0));

    p_count_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] == OPC_CUSTOM0 && insn_i[14:12] == F3_BITOPS
         && insn_i[31:26] == 6'b100001 && insn_i[24:20] == 5'd0)
        |=> (result_o <= XLEN));

    p_btest_onebit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] == OPC_CUSTOM0 && insn_i[14:12] == F3_BITOPS
         && insn_i[31:26] == 6'b100010)
        |=> (result_o[XLEN-1:1] == '0));

    p_rorw_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] == OPC_CUSTOM0 && insn_i[14:12] == F3_BITOPS
         && insn_i[31:25] == 7'b0001010)
        |=> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));

    p_revw_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_i[6:0] == OPC_CUSTOM0 && insn_i[14:12] == F3_BITOPS
         && insn_i[31:25] == 7'b1001000 && insn_i[24:20] == 5'd0)
        |=> (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}));

endmodule

// File: tb/bmx_exec_test.sv
`timescale 1ns/1ps
module bmx_exec_test;

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] rs1;
        logic [63:0] rs2;
        logic [63:0] res;
        logic        wr;
        logic        ill;
        logic [7:0]  req;
    } vec_t;

    function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] r2,
                                       input logic [2:0] f3, input logic [4:0] rd,
                                       input logic [6:0] opc);
        return {f7, r2, 5'd3, f3, rd, opc};
    endfunction

    localparam logic [6:0] C0 = 7'b0001011;
    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{mk(7'b0000000, 5'd2, 3'b001, 5'd5, C0), 64'd100, 64'd23, 64'd123, 1'b1, 1'b0, 8'd3},  // R3
        '{mk(7'b0000011, 5'd2, 3'b001, 5'd5, C0), 64'd1, 64'h10, 64'h81, 1'b1, 1'b0, 8'd3},     // R3
        '{mk(7'b0000001, 5'd2, 3'b001, 5'd5, C0), '1, 64'd1, 64'd1, 1'b1, 1'b0, 8'd3},          // R3
        '{mk(7'b0001000, 5'd4, 3'b001, 5'd5, C0), 64'hF1, 64'd0, 64'h1000_0000_0000_000F, 1'b1, 1'b0, 8'd4}, // R4
        '{mk(7'b0001001, 5'd0, 3'b001, 5'd5, C0), 64'h1122_3344_5566_7788, 64'd0, 64'h5566_7788_1122_3344, 1'b1, 1'b0, 8'd4}, // R4
        '{mk(7'b0001000, 5'd0, 3'b001, 5'd5, C0), 64'hDEAD_BEEF_0000_0001, 64'd0, 64'hDEAD_BEEF_0000_0001, 1'b1, 1'b0, 8'd4}, // R4
        '{mk(7'b0001010, 5'd8, 3'b001, 5'd5, C0), 64'hAAAA_AAAA_1234_5678, 64'd0, 64'h0000_0000_7812_3456, 1'b1, 1'b0, 8'd5}, // R5
        '{mk(7'b0001010, 5'd4, 3'b001, 5'd5, C0), 64'h8, 64'd0, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 8'd5}, // R5
        '{mk(7'b1000011, 5'd0, 3'b001, 5'd5, C0), 64'h1_0000, 64'd0, 64'd47, 1'b1, 1'b0, 8'd6},  // R6
        '{mk(7'b1000011, 5'd0, 3'b001, 5'd5, C0), 64'd0, 64'd0, 64'd64, 1'b1, 1'b0, 8'd6},       // R6
        '{mk(7'b1000010, 5'd0, 3'b001, 5'd5, C0), 64'hFF00_0000_0000_0000, 64'd0, 64'd8, 1'b1, 1'b0, 8'd6}, // R6
        '{mk(7'b1000010, 5'd0, 3'b001, 5'd5, C0), '1, 64'd0, 64'd64, 1'b1, 1'b0, 8'd6},          // R6
        '{mk(7'b1000001, 5'd0, 3'b001, 5'd5, C0), 64'h0102_0304_0506_0708, 64'd0, 64'h0807_0605_0403_0201, 1'b1, 1'b0, 8'd7}, // R7
        '{mk(7'b1001000, 5'd0, 3'b001, 5'd5, C0), 64'h1234_5678, 64'd0, 64'h7856_3412, 1'b1, 1'b0, 8'd8}, // R8
        '{mk(7'b1001000, 5'd0, 3'b001, 5'd5, C0), 64'hFFFF_FFFF_0000_00F0, 64'd0, 64'hFFFF_FFFF_F000_0000, 1'b1, 1'b0, 8'd8}, // R8
        '{mk(7'b1000000, 5'd0, 3'b001, 5'd5, C0), 64'h00FF_0001_0000_1200, 64'd0, 64'hFF00_FF00_FFFF_00FF, 1'b1, 1'b0, 8'd9}, // R9
        '{mk(7'b1000101, 5'd31, 3'b001, 5'd5, C0), 64'h8000_0000_0000_0000, 64'd0, 64'd1, 1'b1, 1'b0, 8'd10}, // R10
        '{mk(7'b1000100, 5'd3, 3'b001, 5'd5, C0), 64'hF7, 64'd0, 64'd0, 1'b1, 1'b0, 8'd10},      // R10
        '{mk(7'b1000100, 5'd0, 3'b001, 5'd5, C0), 64'd1, 64'd0, 64'd1, 1'b1, 1'b0, 8'd10},       // R10
        '{mk(7'b0000000, 5'd2, 3'b000, 5'd5, C0), 64'd7, 64'd7, 64'd0, 1'b0, 1'b1, 8'd11},       // R11
        '{mk(7'b1000011, 5'd1, 3'b001, 5'd5, C0), 64'd7, 64'd7, 64'd0, 1'b0, 1'b1, 8'd11},       // R11
        '{mk(7'b0000100, 5'd2, 3'b001, 5'd5, C0), 64'd7, 64'd7, 64'd0, 1'b0, 1'b1, 8'd11},       // R11
        '{mk(7'b0000000, 5'd2, 3'b001, 5'd0, C0), 64'd100, 64'd23, 64'd123, 1'b0, 1'b0, 8'd12},  // R12
        '{mk(7'b0000000, 5'd2, 3'b001, 5'd5, 7'b0110011), 64'd9, 64'd9, 64'd0, 1'b0, 1'b0, 8'd13} // R13
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] rs1 = '0;
    logic [63:0] rs2 = '0;
    logic [63:0] result;
    logic        wr_en;
    logic        illegal;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    bmx_exec uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_i    (insn),
        .rs1_i     (rs1),
        .rs2_i     (rs2),
        .result_o  (result),
        .wr_en_o   (wr_en),
        .illegal_o (illegal)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4ns * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset wr_en", {63'd0, wr_en}, 64'd0);
        chk("R1 reset illegal", {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            insn = VEC[i].insn;
            rs1  = VEC[i].rs1;
            rs2  = VEC[i].rs2;
            @(negedge clk);
            chk($sformatf("R%0d vec %0d result", VEC[i].req, i), result, VEC[i].res);
            chk($sformatf("R%0d vec %0d wr_en", VEC[i].req, i), {63'd0, wr_en}, {63'd0, VEC[i].wr});
            chk($sformatf("R%0d vec %0d illegal", VEC[i].req, i), {63'd0, illegal}, {63'd0, VEC[i].ill});
        end

        // R2: new input is not visible before the next rising edge
        @(negedge clk);
        insn = mk(7'b0000000, 5'd2, 3'b001, 5'd5, C0);
        rs1 = 64'd1;
        rs2 = 64'd1;
        @(negedge clk);
        chk("R2 first sum", result, 64'd2);
        rs1 = 64'd5;
        rs2 = 64'd5;
        #1;
        chk("R2 held until edge", result, 64'd2);
        @(negedge clk);
        chk("R2 after edge", result, 64'd10);

        // R1: asynchronous reset clears live outputs
        rst_n = 1'b0;
        #1;
        chk("R1 async clear result", result, 64'd0);
        chk("R1 async clear wr_en", {63'd0, wr_en}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R13 after R11: a foreign opcode clears a standing illegal flag
        insn = mk(7'b1111111, 5'd0, 3'b001, 5'd5, C0);
        @(negedge clk);
        chk("R11 unlisted funct7 illegal", {63'd0, illegal}, 64'd1);
        insn = mk(7'b1000011, 5'd0, 3'b001, 5'd5, 7'b0010011);
        @(negedge clk);
        chk("R13 foreign opcode illegal", {63'd0, illegal}, 64'd0);
        chk("R13 foreign opcode wr_en", {63'd0, wr_en}, 64'd0);

        done = 1'b1;
        finish_run();
    end

endmodule